// File: doc/BRIEF.md
# Split-Screen Palette Register File

The block keeps eight 8-bit colour entries. Each entry holds a hue in bits 7:3 and a brightness in bits 2:0. Every clock it turns a 2-bit pixel code into one of those entries. Entries 0–3 form the right-hand bank and entries 4–7 form the left-hand bank. A programmable column boundary picks the bank for each pixel from the pixel's horizontal position. Scan lines at or below a programmable blanking line show a frame colour instead of pixel colours. The frame colour is taken from the left-hand bank.

A host programs the block through a single write port, using an address, data, a write strobe and a burst-mode flag. Addresses 0–7 write the colour entries directly. Address 8 selects the resolution. Address 9 holds the boundary column in bits 5:0 and the frame-colour index in bits 7:6. Address 10 holds the blanking line. In burst mode, repeated writes to address 11 fill entries 7 down to 0, one entry per write. The colour output is registered, so it shows the result for the inputs and register contents seen at the previous clock edge.

Top module: `split_palette`

## Requirements
- R1: While reset is active, and on the first cycle after reset is released, `color_out` is 0, every register is 0 and the burst pointer is at entry 7.
- R2: A write with `wr_en`=1 to address 0–7 stores `wr_data` in colour entry 0–7. Entries 0–3 are the right bank and entries 4–7 are the left bank, each addressed by `pix_code`.
- R3: In low-resolution mode (address 8 bit 0 = 0), the pixel column is `hpos`/4. Column ≥ boundary (address 9 bits 5:0) selects right-bank entry `pix_code`. Column < boundary selects left-bank entry 4+`pix_code`.
- R4: In high-resolution mode (address 8 bit 0 = 1), the pixel column is `hpos`/8, and the same comparison applies.
- R5: When `vpos` ≥ the blanking line (address 10), the output is entry 4 + (address 9 bits 7:6), whatever the pixel code and position.
- R6: Writes to address 11 with `burst_mode`=1 load entries 7, 6, …, 0 in that order, one per write. The write after entry 0 loads entry 7 again.
- R7: Any other write, including a write to address 11 with `burst_mode`=0, returns the burst pointer to entry 7. A write to address 11 with `burst_mode`=0 changes no register.
- R8: Writes to addresses 12–31 change no register and no output.
- R9: `color_out` is registered. It reflects the inputs and register contents at the previous rising edge, so a write becomes visible on the output one cycle after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Write data |
| burst_mode | input | 1 | Selects burst (block-transfer) loading for address 11 |
| hpos | input | 9 | Current horizontal pixel position |
| vpos | input | 8 | Current scan line |
| pix_code | input | 2 | Pixel colour code |
| color_out | output | 8 | Registered hue/brightness of the current pixel |

## Verification
The bench targets the columns on each side of the boundary in both resolutions. A design with an off-by-one compare, or with the wrong divisor, would paint the boundary column from the wrong bank. It also uses the line just above the blanking line and the blanking line itself, so an exclusive compare there would show pixel colour on the first blanked line. Burst sequences run past entry 0 and are interrupted by ordinary writes and by non-burst writes to the burst address. A pointer that counts upward, fails to wrap, or is not rewound would show up as the wrong entry changing. Writes to unused addresses are interleaved throughout, and any aliasing onto real registers would alter the colours observed afterwards.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int ADDR_MODE  = 8;
  localparam int ADDR_EDGE  = 9;
  localparam int ADDR_VBL   = 10;
  localparam int ADDR_BURST = 11;
endpackage

// File: rtl/palette_burst_ptr.sv
module palette_burst_ptr #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             burst_hit,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_d, ptr_q;
  logic             ptr_en;

  always_comb begin
    ptr_en = wr_en;
    if (burst_hit) ptr_d = ptr_q - 1'b1;
    else           ptr_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '1;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/palette_regfile.sv
module palette_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   burst_hit,
  input  logic [IDX_W-1:0]       ptr,
  output logic [NREG*DATA_W-1:0] pal_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_entry
    logic              we;
    logic [DATA_W-1:0] q;
    always_comb begin
      we = (wr_en && !burst_hit && wr_addr == ADDR_W'(i))
        || (burst_hit && ptr == IDX_W'(i));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wr_data;
    end
    assign pal_flat[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/palette_ctrl_regs.sv
module palette_ctrl_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hires,
  output logic [DATA_W-1:0] edge_reg,
  output logic [DATA_W-1:0] vbl_reg
);
  import palette_pkg::*;
  logic mode_we, edge_we, vbl_we;

  always_comb begin
    mode_we = wr_en && wr_addr == ADDR_W'(ADDR_MODE);
    edge_we = wr_en && wr_addr == ADDR_W'(ADDR_EDGE);
    vbl_we  = wr_en && wr_addr == ADDR_W'(ADDR_VBL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hires    <= 1'b0;
      edge_reg <= '0;
      vbl_reg  <= '0;
    end else begin
      if (mode_we) hires    <= wr_data[0];
      if (edge_we) edge_reg <= wr_data;
      if (vbl_we)  vbl_reg  <= wr_data;
    end
  end
endmodule

// File: rtl/palette_pix_sel.sv
module palette_pix_sel #(
  parameter int CODE_W = 2,
  parameter int DATA_W = 8,
  parameter int HPOS_W = 9
) (
  input  logic [(2**(CODE_W+1))*DATA_W-1:0] pal_flat,
  input  logic                              hires,
  input  logic [DATA_W-1:0]                 edge_reg,
  input  logic [DATA_W-1:0]                 vbl_reg,
  input  logic [HPOS_W-1:0]                 hpos,
  input  logic [DATA_W-1:0]                 vpos,
  input  logic [CODE_W-1:0]                 pix_code,
  output logic [DATA_W-1:0]                 color_d
);
  localparam int BND_W = DATA_W - CODE_W;
  localparam int IDX_W = CODE_W + 1;

  logic [HPOS_W-1:0] col;
  logic [HPOS_W-1:0] bnd;
  logic              right_side;
  logic              blanked;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    col        = hires ? (hpos >> 3) : (hpos >> 2);
    bnd        = {{(HPOS_W-BND_W){1'b0}}, edge_reg[BND_W-1:0]};
    right_side = col >= bnd;
    blanked    = vpos >= vbl_reg;
    if (blanked) idx = {1'b1, edge_reg[DATA_W-1 -: CODE_W]};
    else         idx = {~right_side, pix_code};
    color_d = pal_flat[idx*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/split_palette.sv
module split_palette #(
  parameter int CODE_W = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int HPOS_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              burst_mode,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [DATA_W-1:0] vpos,
  input  logic [CODE_W-1:0] pix_code,
  output logic [DATA_W-1:0] color_out
);
  import palette_pkg::*;
  localparam int IDX_W = CODE_W + 1;
  localparam int NREG  = 2 ** IDX_W;

  logic                   rst_m, rst_s;
  logic                   burst_hit;
  logic [IDX_W-1:0]       ptr;
  logic [NREG*DATA_W-1:0] pal_flat;
  logic                   hires;
  logic [DATA_W-1:0]      edge_reg, vbl_reg;
  logic [DATA_W-1:0]      color_d, color_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_m} <= 2'b00;
    else        {rst_s, rst_m} <= {rst_m, 1'b1};
  end

  assign burst_hit = wr_en && burst_mode && wr_addr == ADDR_W'(ADDR_BURST);

  palette_burst_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .burst_hit(burst_hit), .ptr(ptr)
  );

  palette_regfile #(.NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .burst_hit(burst_hit), .ptr(ptr), .pal_flat(pal_flat)
  );

  palette_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hires(hires), .edge_reg(edge_reg), .vbl_reg(vbl_reg)
  );

  palette_pix_sel #(.CODE_W(CODE_W), .DATA_W(DATA_W), .HPOS_W(HPOS_W)) u_sel (
    .pal_flat(pal_flat), .hires(hires), .edge_reg(edge_reg), .vbl_reg(vbl_reg),
    .hpos(hpos), .vpos(vpos), .pix_code(pix_code), .color_d(color_d)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) color_q <= '0;
    else        color_q <= color_d;
  end

  assign color_out = color_q;
endmodule

// File: rtl/palette_chk.sv
module palette_chk #(
  parameter int CODE_W = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int HPOS_W = 9,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              burst_mode,
  input logic [HPOS_W-1:0] hpos,
  input logic [DATA_W-1:0] vpos,
  input logic [CODE_W-1:0] pix_code,
  input logic [DATA_W-1:0] color_out,
  input logic [IDX_W-1:0]  ptr
);
  localparam logic [ADDR_W-1:0] BURST_A = ADDR_W'(palette_pkg::ADDR_BURST);

  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_ns) |-> (color_out == '0 && ptr == '1));

  p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && burst_mode && wr_addr == BURST_A) |=> ptr == IDX_W'($past(ptr) - 1'b1));

  p_ptr_rewind_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (wr_en && !(burst_mode && wr_addr == BURST_A)) |=> ptr == '1);

  p_ptr_idle_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !wr_en |=> $stable(ptr));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (!wr_en && $past(!wr_en) && $stable(hpos) && $stable(vpos) && $stable(pix_code))
      |=> $stable(color_out));
endmodule

bind split_palette palette_chk #(
  .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HPOS_W(HPOS_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_ns(rst_s), .wr_en(wr_en), .wr_addr(wr_addr), .burst_mode(burst_mode),
  .hpos(hpos), .vpos(vpos), .pix_code(pix_code), .color_out(color_out), .ptr(ptr)
);

// File: tb/tb_split_palette.sv
module tb_split_palette;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       burst_mode = 1'b0;
  logic [8:0] hpos = '0;
  logic [7:0] vpos = '0;
  logic [1:0] pix_code = '0;
  logic [7:0] color_out;

  split_palette dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .burst_mode(burst_mode), .hpos(hpos), .vpos(vpos), .pix_code(pix_code),
    .color_out(color_out)
  );

  always #2 clk = ~clk;

  int    total = 0, bad = 0;
  bit    cmp_on = 0;
  string tag = "R1";

  // behavioural reference model
  int m_pal[8];
  int m_mode, m_bnd, m_vbl, m_ptr;
  int exp_q = 0;

  function automatic int model_color(int h, int v, int c);
    int col;
    if (v >= m_vbl) return m_pal[4 + (m_bnd >> 6)];
    col = (m_mode != 0) ? h / 8 : h / 4;
    if (col >= (m_bnd & 63)) return m_pal[c];
    return m_pal[4 + c];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pal[i]) m_pal[i] = 0;
      m_mode = 0; m_bnd = 0; m_vbl = 0; m_ptr = 7; exp_q = 0;
    end else begin
      exp_q = model_color(int'(hpos), int'(vpos), int'(pix_code));
      if (wr_en) begin
        if (wr_addr == 5'd11 && burst_mode) begin
          m_pal[m_ptr] = int'(wr_data);
          m_ptr = (m_ptr == 0) ? 7 : m_ptr - 1;
        end else begin
          m_ptr = 7;
          if (wr_addr < 5'd8) m_pal[wr_addr] = int'(wr_data);
          else if (wr_addr == 5'd8)  m_mode = int'(wr_data[0]);
          else if (wr_addr == 5'd9)  m_bnd  = int'(wr_data);
          else if (wr_addr == 5'd10) m_vbl  = int'(wr_data);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      total++;
      if (color_out !== 8'(exp_q)) begin
        bad++;
        $display("FAIL %s: color_out=%0h expected=%0h (h=%0d v=%0d c=%0d)",
                 tag, color_out, exp_q[7:0], hpos, vpos, pix_code);
      end
    end
  end

  task automatic wr(input int a, input int d, input bit b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d); burst_mode = b;
    @(negedge clk);
    wr_en = 1'b0; burst_mode = 1'b0;
  endtask

  task automatic px(input int h, input int v, input int c);
    @(negedge clk);
    hpos = 9'(h); vpos = 8'(v); pix_code = 2'(c);
  endtask

  task automatic sweep_all_codes();
    for (int i = 0; i < 8; i++) for (int c = 0; c < 4; c++) px(0, 10, c);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    total++;
    if (color_out !== 8'h00) begin
      bad++; $display("FAIL R1: color_out=%0h expected=0 in reset", color_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (color_out !== 8'h00) begin
      bad++; $display("FAIL R1: color_out=%0h expected=0 after reset", color_out);
    end
    cmp_on = 1;

    // R2: direct writes into both banks
    tag = "R2";
    wr(10, 200, 0);
    for (int i = 0; i < 8; i++) wr(i, 8'h11 * (i + 1) + 3, 0);
    for (int c = 0; c < 4; c++) px(0, 10, c);
    wr(9, 20, 0);
    for (int c = 0; c < 4; c++) px(0, 10, c);

    // R3: low resolution boundary, column = hpos/4
    tag = "R3";
    wr(9, 10, 0);
    for (int h = 30; h < 50; h++) for (int c = 0; c < 4; c++) px(h, 50, c);
    wr(9, 0, 0);
    px(0, 5, 1); px(159, 5, 2);
    wr(9, 63, 0);
    px(159, 5, 3); px(0, 5, 0);

    // R4: high resolution, column = hpos/8
    tag = "R4";
    wr(8, 8'hFF, 0);
    wr(9, 10, 0);
    for (int h = 70; h < 90; h++) for (int c = 0; c < 4; c++) px(h, 50, c);
    px(319, 20, 2); px(0, 20, 2);
    wr(8, 0, 0);
    px(79, 20, 1); px(80, 20, 1);

    // R5: border below the blanking line, each frame index
    tag = "R5";
    for (int f = 0; f < 4; f++) begin
      wr(9, (f << 6) | 10, 0);
      px(100, 199, 0); px(100, 200, 0); px(100, 201, 3); px(5, 255, 2);
    end
    wr(10, 0, 0);
    px(0, 0, 1);
    wr(10, 200, 0);
    wr(9, 10, 0);

    // R6: descending burst with wrap
    tag = "R6";
    for (int k = 0; k < 10; k++) begin
      wr(11, 8'h80 + k, 1);
      for (int c = 0; c < 4; c++) begin px(0, 10, c); px(100, 10, c); end
    end

    // R7: interrupted bursts rewind the pointer
    tag = "R7";
    wr(11, 8'h21, 1); wr(11, 8'h22, 1); wr(11, 8'h23, 1);
    wr(2, 8'h5A, 0);
    wr(11, 8'h24, 1);
    for (int c = 0; c < 4; c++) begin px(0, 10, c); px(100, 10, c); end
    wr(11, 8'h31, 1); wr(11, 8'h32, 1);
    wr(11, 8'hEE, 0);
    wr(11, 8'h33, 1);
    for (int c = 0; c < 4; c++) begin px(0, 10, c); px(100, 10, c); end
    wr(11, 8'h41, 1);
    wr(25, 8'h00, 0);
    wr(11, 8'h42, 1);
    for (int c = 0; c < 4; c++) begin px(0, 10, c); px(100, 10, c); end

    // R8: unused addresses alter nothing
    tag = "R8";
    for (int a = 12; a < 32; a++) begin
      wr(a, 8'hFF - a, 0);
      px(a, 10, a % 4); px(100, 10, a % 4);
    end
    px(100, 220, 0);

    // R9: write visible one cycle later at a fixed pixel
    tag = "R9";
    px(100, 10, 1);
    wr(1, 8'hC7, 0);
    px(100, 10, 1);
    wr(1, 8'h38, 0);
    repeat (3) @(negedge clk);

    cmp_on = 0;
    finish_run();
  end
endmodule